// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target. It lets a bus master read and write a bank of 8-bit registers that sit outside the block. The 7-bit device address is `001100` followed by one bit taken from a strap input. With the strap tied high the target answers at 0x19, and with it tied low it answers at 0x18, so two targets can share one bus.

After a write address byte, the master sends a pointer byte. Bits 6:0 of that byte select the first register. Bit 7 chooses whether the pointer steps forward after each byte. Any further bytes in the same write go to the register file. To read, the master first writes the pointer byte. It then issues a repeated START and the read address, and then clocks data out. Each data byte ends with a master ACK to ask for more, or a NACK to end the read.

SCL and SDA are sampled with the system clock through two-flop synchronizers, and SDA is driven open-drain through an output enable. The register file port has no handshake. A write is a single-cycle strobe that the register bank must accept on the spot. Read data must follow `reg_addr` combinationally, or at least settle within a few system clocks. Neither direction supports back-pressure. The design assumes a system clock of at least about 20 times the SCL rate, which covers both 100 kbit/s and 400 kbit/s.

Top module: `i2c_reg_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal `001100` followed by `addr_strap`. Bit 0 of that byte is the direction, with 1 meaning read. With the strap high, 0x32 and 0x33 are acknowledged; with it low, 0x30 and 0x31 are.
- R2: After an address byte that does not match, the target gives no ACK, performs no register write and acknowledges nothing until the next START.
- R3: In a write, the first byte after the address is the pointer byte. Each later byte produces exactly one single-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The target ACKs the pointer byte and every data byte.
- R4: When pointer bit 7 is 0, the pointer does not move. Repeated writes land in the same register, and repeated reads return the same register.
- R5: When pointer bit 7 is 1, the pointer increments after every data byte, written or read, and wraps from 0x7F to 0x00.
- R6: After a repeated START and a read address, the target sends the register at the pointer MSB first. A master ACK makes it send the next byte. After a master NACK, the target leaves SDA released.
- R7: A START or STOP seen in the middle of a byte aborts the transfer without writing the partial byte. The pointer is kept across a repeated START.
- R8: `sda_oe` is asserted only while SCL is low.
- R9: While reset is active, `sda_oe` and `reg_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| addr_strap | input | 1 | Selects the low bit of the device address |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 7 | Register pointer |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Read data for `reg_addr` |

## Verification
The bench aims at the pointer wrap from 0x7F to 0x00. A design that forgot the wrap would write a register that does not exist, or read back the wrong byte. It also sends repeated writes and reads with auto-increment off. A design that always stepped the pointer would scatter those bytes across neighbouring registers. It cuts a data byte short with STOP, and separately with a repeated START. A design that wrote partial bytes would change the register, and one that lost the pointer would read back the wrong one. A mismatched address is followed by more bytes, and any ACK or write after it would expose a target that failed to go deaf. A monitor flags SDA being pulled low while SCL is high, which would corrupt START and STOP detection.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_SUB, S_WDAT, S_ACK, S_TX, S_MACK
  } tgt_state_t;

  typedef enum logic [1:0] {
    K_ADDR, K_SUB, K_WDAT
  } ack_kind_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] cur,
  output logic [LINES-1:0] prv
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], raw[g]};
    end
    assign cur[g] = sh[STAGES-1];
    assign prv[g] = sh[STAGES];
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic scl,
  input  logic sda,
  input  logic scl_p,
  input  logic sda_p,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  always_comb begin
    scl_rise  = scl & ~scl_p;
    scl_fall  = ~scl & scl_p;
    start_det = scl & scl_p & sda_p & ~sda;
    stop_det  = scl & scl_p & ~sda_p & sda;
  end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int         AW      = 7,
  parameter int         DW      = 8,
  parameter logic [5:0] ADDR_HI = 6'b001100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap,
  input  logic          sda,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  tgt_state_t    st;
  ack_kind_t     kind;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rx_sr, tx_sr;
  logic [AW-1:0] ptr;
  logic          inc, rw, mack;

  assign reg_addr  = ptr;
  assign reg_wdata = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_ADDR; cnt <= '0;
      rx_sr <= '0; tx_sr <= '0; ptr <= '0;
      inc <= 1'b0; rw <= 1'b0; mack <= 1'b0;
      sda_oe <= 1'b0; reg_we <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_SUB, S_WDAT: begin
            if (scl_rise && cnt != FULL) begin
              rx_sr <= {rx_sr[DW-2:0], sda};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              case (st)
                S_ADDR: begin
                  if (rx_sr[7:1] == {ADDR_HI, strap}) begin
                    rw <= rx_sr[0]; kind <= K_ADDR;
                    sda_oe <= 1'b1; st <= S_ACK;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                S_SUB: begin
                  ptr <= rx_sr[AW-1:0]; inc <= rx_sr[DW-1];
                  kind <= K_SUB; sda_oe <= 1'b1; st <= S_ACK;
                end
                default: begin
                  reg_we <= 1'b1; kind <= K_WDAT;
                  sda_oe <= 1'b1; st <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              case (kind)
                K_ADDR: begin
                  if (rw) begin
                    tx_sr <= reg_rdata; sda_oe <= ~reg_rdata[DW-1];
                    cnt <= '0; st <= S_TX;
                  end else begin
                    st <= S_SUB;
                  end
                end
                K_SUB: st <= S_WDAT;
                default: begin
                  if (inc) ptr <= ptr + AW'(1);
                  st <= S_WDAT;
                end
              endcase
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0; st <= S_MACK;
              end else begin
                tx_sr  <= {tx_sr[DW-2:0], 1'b0};
                sda_oe <= ~tx_sr[DW-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda;
              if (inc) ptr <= ptr + AW'(1);
            end else if (scl_fall) begin
              if (mack) begin
                tx_sr <= reg_rdata; sda_oe <= ~reg_rdata[DW-1];
                cnt <= '0; st <= S_TX;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int         AW      = 7,
  parameter int         DW      = 8,
  parameter int         SYNC    = 2,
  parameter logic [5:0] ADDR_HI = 6'b001100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_strap,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  logic [1:0] ln_cur, ln_prv;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({sda_i, scl_i}),
    .cur(ln_cur), .prv(ln_prv)
  );

  assign scl_s = ln_cur[0];
  assign sda_s = ln_cur[1];

  i2c_bus_events u_evt (
    .scl(scl_s), .sda(sda_s), .scl_p(ln_prv[0]), .sda_p(ln_prv[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_ctrl #(.AW(AW), .DW(DW), .ADDR_HI(ADDR_HI)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strap(addr_strap), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic stop_det,
  input logic sda_oe,
  input logic reg_we
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  always @(negedge clk)
    if (!rst_n && armed)
      assert_reset_idle_R9: assert (!sda_oe && !reg_we);

  assert_oe_low_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_we_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_we_with_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> sda_oe);

  assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe(sda_oe), .reg_we(reg_we)
);

// File: tb/i2c_reg_target_test.sv
`timescale 1ns/1ps
module i2c_reg_target_test;
  localparam real CLK_NS = 5.0;
  localparam real Q = 200.0;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [128];
  logic [7:0] rbuf [4];
  wire sda_bus = sda_m & ~sda_oe;
  int checks = 0, errors = 0, we_count = 0, oe_bad = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  i2c_reg_target uut (
    .clk(clk), .rst_n(rst_n), .addr_strap(strap), .scl_i(scl_m),
    .sda_i(sda_bus), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) begin
    mem[reg_addr] <= reg_wdata;
    we_count <= we_count + 1;
  end
  always @(posedge sda_oe) if (scl_m) oe_bad++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bstart();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask
  task automatic bstop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask
  task automatic wbit(input logic v);
    sda_m = v; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
  endtask
  task automatic rbit(output logic v);
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; v = sda_bus; #Q; scl_m = 1'b0; #Q;
  endtask
  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(v); ack = ~v;
  endtask
  task automatic rbyte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~ack);
  endtask

  task automatic wr_seq(input logic [7:0] sub, input int n,
                        input logic [7:0] d0, d1, d2, output int acks);
    logic a;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2; acks = 0;
    bstart(); wbyte(8'h32, a); acks += a;
    wbyte(sub, a); acks += a;
    for (int i = 0; i < n; i++) begin wbyte(d[i], a); acks += a; end
    bstop();
  endtask

  task automatic rd_seq(input logic [7:0] sub, input int n);
    logic a;
    bstart(); wbyte(8'h32, a); wbyte(sub, a);
    bstart(); wbyte(8'h33, a);
    for (int i = 0; i < n; i++) rbyte(rbuf[i], i != n-1);
    chk("R6 sda released after NACK", sda_oe, 0);
    bstop();
  endtask

  task automatic t_reset();
    chk("R9 sda_oe in reset", sda_oe, 0);
    chk("R9 reg_we in reset", reg_we, 0);
  endtask

  task automatic t_addr_match();
    logic a;
    bstart(); wbyte(8'h32, a); bstop(); chk("R1 ack 0x32", a, 1);
    bstart(); wbyte(8'h33, a); rbyte(rbuf[0], 1'b0); bstop();
    chk("R1 ack 0x33", a, 1);
  endtask

  task automatic t_addr_miss();
    logic a0, a1, a2;
    int w0 = we_count;
    bstart(); wbyte(8'h30, a0); wbyte(8'h05, a1); wbyte(8'hEE, a2); bstop();
    chk("R2 no ack for 0x30", a0, 0);
    chk("R2 deaf after miss", a1 | a2, 0);
    chk("R2 no write after miss", we_count - w0, 0);
  endtask

  task automatic t_fixed_write();
    int acks;
    wr_seq(8'h05, 2, 8'hA1, 8'hB2, 8'h00, acks);
    chk("R3 all bytes acked", acks, 4);
    chk("R4 fixed reg gets last byte", mem[5], 8'hB2);
    chk("R4 neighbour untouched", mem[6], 8'h06 ^ 8'h5A);
  endtask

  task automatic t_burst();
    int acks;
    wr_seq(8'h90, 3, 8'h11, 8'h22, 8'h33, acks);
    chk("R3 burst acks", acks, 5);
    chk("R5 burst reg 0x10", mem[8'h10], 8'h11);
    chk("R5 burst reg 0x12", mem[8'h12], 8'h33);
    rd_seq(8'h90, 3);
    chk("R6 read byte 0", rbuf[0], 8'h11);
    chk("R5 read byte 1", rbuf[1], 8'h22);
    chk("R5 read byte 2", rbuf[2], 8'h33);
    rd_seq(8'h10, 2);
    chk("R4 fixed read 0", rbuf[0], 8'h11);
    chk("R4 fixed read 1", rbuf[1], 8'h11);
  endtask

  task automatic t_wrap();
    int acks;
    wr_seq(8'hFE, 3, 8'hC1, 8'hC2, 8'hC3, acks);
    chk("R5 write 0x7E", mem[8'h7E], 8'hC1);
    chk("R5 write 0x7F", mem[8'h7F], 8'hC2);
    chk("R5 wrap to 0x00", mem[0], 8'hC3);
    rd_seq(8'hFF, 2);
    chk("R5 read 0x7F", rbuf[0], 8'hC2);
    chk("R5 read wrap 0x00", rbuf[1], 8'hC3);
  endtask

  task automatic t_abort();
    logic a;
    int w0 = we_count;
    bstart(); wbyte(8'h32, a); wbyte(8'h03, a);
    wbit(1); wbit(1); wbit(1); wbit(1); bstop();
    chk("R7 stop drops partial byte", we_count - w0, 0);
    chk("R7 reg 3 intact", mem[3], 8'h03 ^ 8'h5A);
    bstart(); wbyte(8'h32, a); wbyte(8'h04, a);
    wbit(0); wbit(0); wbit(0); wbit(0);
    bstart(); wbyte(8'h33, a); rbyte(rbuf[0], 1'b0); bstop();
    chk("R7 no write on restart", we_count - w0, 0);
    chk("R7 pointer kept over restart", rbuf[0], 8'h04 ^ 8'h5A);
  endtask

  task automatic t_strap0();
    logic a0, a1;
    strap = 1'b0; #Q;
    bstart(); wbyte(8'h30, a0); bstop();
    bstart(); wbyte(8'h32, a1); bstop();
    chk("R1 strap low acks 0x30", a0, 1);
    chk("R2 strap low rejects 0x32", a1, 0);
    strap = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (10) @(posedge clk);
    @(negedge clk); t_reset();
    rst_n = 1'b1; #(4*Q);
    t_addr_match();
    t_addr_miss();
    t_fixed_write();
    t_burst();
    t_wrap();
    t_abort();
    t_strap0();
    chk("R8 no drive while SCL high", oe_bad, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 190000.0);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule